// File: doc/BRIEF.md
# Guest Event Exit Filter

This block sits in the event-delivery path of a virtualising processor core. Each time an event is about to be delivered to a guest (an external interrupt, a non-maskable interrupt, a hardware exception, a software exception, a privileged software interrupt or a plain software interrupt), the core presents it on one cycle. The block then decides whether the hypervisor must take control. If it must, the block emits a one-cycle exit strobe with a packed interruption-information word, the error code and a qualification value. If it need not, the block updates a deferred vectoring record that the core later copies out, and nothing exits.

The decision depends on the event type. Two pin-level enables govern interrupts and NMIs. A per-vector exception bitmap governs the exception-class types. Page faults are the special case: the event's error code is masked and compared with a match value, and the outcome of that comparison must equal the page-fault bitmap bit for an exit to occur. The block also keeps two status flags. One is an NMI-unblocking flag, which is reported in exit words and cleared whenever an event is recorded rather than exited. The other is an in-delivery flag, which a double-fault exit clears.

Top module: `gx_event_filter`

## Requirements
- R1: An event of type 0 (external interrupt) exits when `ctl_extint_exit` is 1 and is recorded when it is 0.
- R2: An event of type 2 (NMI) exits when `ctl_nmi_exit` is 1 and is recorded when it is 0.
- R3: For types 3 (hardware exception), 5 (privileged software interrupt) and 6 (software exception) with a vector below 32 other than 14, the event exits exactly when `exc_bitmap[vector]` is 1; otherwise it is recorded.
- R4: For an exception-class event with vector 14, the event exits exactly when the comparison `((evt_errcode & pf_err_mask) == pf_err_match)` gives the same value as `exc_bitmap[14]`.
- R5: An event of type 4 (software interrupt) never exits; it is always recorded.
- R6: On an exit, `exit_stb` pulses in the cycle after the event. In that cycle `exit_info` holds the vector in bits 7:0, the type in bits 10:8, the error-valid flag in bit 11, the NMI-unblocking flag (as it stood when the event was presented) in bit 12, 1 in bit 31 and 0 in bits 30:13. `exit_errcode` holds the event's error code.
- R7: On a recorded event, `rec_upd` pulses in the cycle after the event. `rec_info` takes the same vector, type and error-valid fields with bits 31:12 all 0, `rec_errcode` takes the error code, and `nmi_unblock` reads 0 from that cycle on.
- R8: On an exit with vector 1, `exit_qual` equals `dbg_trap & 16'h600F`; on every other exit `exit_qual` is 0.
- R9: An exit with vector 8 clears `in_delivery`, and the cleared value is visible in the same cycle as the exit strobe.
- R10: An exception-class event with a vector of 32 or more, or an event of type 1 or 7, pulses `evt_bad` in the next cycle. It produces neither an exit nor a record, and it leaves `exit_info`, `rec_info` and both flags unchanged.
- R11: After reset every output is 0.
- R12: Each presented event produces exactly one of `exit_stb`, `rec_upd` or `evt_bad`, for exactly one cycle, and none of them rises without an event.
- R13: `iret_unblock_set` and `delivery_start` each set their flag (`nmi_unblock`, `in_delivery`) in the next cycle; a clear caused by an event in the same cycle takes precedence over a set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_valid | input | 1 | An event is presented this cycle |
| evt_kind | input | 3 | Event type code (0 ext int, 2 NMI, 3 hw exc, 4 sw int, 5 priv sw int, 6 sw exc) |
| evt_vector | input | 8 | Event vector |
| evt_errcode | input | 16 | Error code carried by the event |
| evt_err_valid | input | 1 | Error code is delivered with the event |
| ctl_extint_exit | input | 1 | External interrupts cause exits |
| ctl_nmi_exit | input | 1 | NMIs cause exits |
| exc_bitmap | input | NUM_EXC (32) | Per-vector exception exit bitmap |
| pf_err_mask | input | 16 | Page-fault error-code mask |
| pf_err_match | input | 16 | Page-fault error-code match value |
| iret_unblock_set | input | 1 | Sets the NMI-unblocking flag |
| delivery_start | input | 1 | Sets the in-delivery flag |
| dbg_trap | input | 16 | Pending debug-trap status |
| exit_stb | output | 1 | One-cycle exit strobe |
| exit_info | output | 32 | Exit interruption-information word |
| exit_errcode | output | 16 | Error code reported with the exit |
| exit_qual | output | 16 | Exit qualification |
| rec_upd | output | 1 | One-cycle strobe: vectoring record updated |
| rec_info | output | 32 | Deferred vectoring information |
| rec_errcode | output | 16 | Deferred vectoring error code |
| evt_bad | output | 1 | One-cycle strobe: event rejected as malformed |
| nmi_unblock | output | 1 | NMI-unblocking flag |
| in_delivery | output | 1 | In-event-delivery flag |

## Verification
The properties assume that each event is seen on one cycle, together with the controls, bitmap and page-fault values that apply to it, so that the previous-cycle inputs decide the current strobe. They also assume that an event and a flag-set pulse can coincide, in which case the clear has to win. The stimulus keeps the configuration constant across each sweep. It places every event on its own cycle and separates it from the flag-set pulses, so the flag model in the bench follows a plain sequence. A single directed case then drives a set pulse together with a recorded event to exercise the collision. The sweep covers every type code, vectors 0 to 39 with both error-valid values, and four combinations of bitmap, enables and page-fault mask.

// File: rtl/gx_event_pkg.sv
package gx_event_pkg;

    localparam int GX_VEC_W  = 8;
    localparam int GX_KIND_W = 3;
    localparam int GX_ERR_W  = 16;
    localparam int GX_INFO_W = 32;
    localparam int GX_QUAL_W = 16;

    localparam int INFO_KIND_LSB  = 8;
    localparam int INFO_ERRV_BIT  = 11;
    localparam int INFO_NMI_BIT   = 12;
    localparam int INFO_VALID_BIT = 31;

    localparam logic [GX_QUAL_W-1:0] DBG_QUAL_KEEP = 16'h600F;

    localparam logic [GX_VEC_W-1:0] VEC_DEBUG  = 8'd1;
    localparam logic [GX_VEC_W-1:0] VEC_DFAULT = 8'd8;
    localparam logic [GX_VEC_W-1:0] VEC_PFAULT = 8'd14;

    typedef enum logic [GX_KIND_W-1:0] {
        EV_EXTINT = 3'd0,
        EV_RSVD1  = 3'd1,
        EV_NMI    = 3'd2,
        EV_HWEXC  = 3'd3,
        EV_SWINT  = 3'd4,
        EV_PRIVSW = 3'd5,
        EV_SWEXC  = 3'd6,
        EV_RSVD7  = 3'd7
    } ev_kind_e;

    typedef enum logic [1:0] {
        OUT_NONE   = 2'd0,
        OUT_EXIT   = 2'd1,
        OUT_RECORD = 2'd2,
        OUT_ERROR  = 2'd3
    } ev_outcome_e;

    typedef struct packed {
        ev_kind_e               kind;
        logic [GX_VEC_W-1:0]    vector;
        logic [GX_ERR_W-1:0]    errcode;
        logic                   err_valid;
    } ev_req_t;

    function automatic logic is_exc_kind(ev_kind_e k);
        return (k == EV_HWEXC) || (k == EV_PRIVSW) || (k == EV_SWEXC);
    endfunction

    function automatic logic [GX_INFO_W-1:0] pack_info(ev_req_t r, logic nmi, logic valid);
        logic [GX_INFO_W-1:0] w;
        w = '0;
        w[GX_VEC_W-1:0]                         = r.vector;
        w[INFO_KIND_LSB +: GX_KIND_W]           = r.kind;
        w[INFO_ERRV_BIT]                        = r.err_valid;
        w[INFO_NMI_BIT]                         = nmi;
        w[INFO_VALID_BIT]                       = valid;
        return w;
    endfunction

endpackage

// File: rtl/gx_exc_select.sv
module gx_exc_select
    import gx_event_pkg::*;
#(
    parameter int NUM_EXC = 32
) (
    input  logic [NUM_EXC-1:0]  exc_bitmap,
    input  logic [GX_VEC_W-1:0] vector,
    output logic                bit_hit,
    output logic                in_range
);
    logic [NUM_EXC-1:0] sel;

    generate
        for (genvar g = 0; g < NUM_EXC; g++) begin : g_sel
            assign sel[g] = (vector == GX_VEC_W'(g)) && exc_bitmap[g];
        end
    endgenerate

    assign bit_hit  = |sel;
    assign in_range = (32'(vector) < NUM_EXC);
endmodule

// File: rtl/gx_pf_filter.sv
module gx_pf_filter #(
    parameter int ERR_W = 16
) (
    input  logic [ERR_W-1:0] errcode,
    input  logic [ERR_W-1:0] mask,
    input  logic [ERR_W-1:0] match,
    input  logic             pf_bit,
    output logic             pf_exit
);
    logic code_match;

    assign code_match = ((errcode & mask) == match);
    assign pf_exit    = (code_match == pf_bit);
endmodule

// File: rtl/gx_exit_decide.sv
module gx_exit_decide
    import gx_event_pkg::*;
#(
    parameter int NUM_EXC = 32,
    parameter int PF_VEC  = 14
) (
    input  ev_req_t              req,
    input  logic                 extint_exit_en,
    input  logic                 nmi_exit_en,
    input  logic [NUM_EXC-1:0]   exc_bitmap,
    input  logic [GX_ERR_W-1:0]  pf_mask,
    input  logic [GX_ERR_W-1:0]  pf_match,
    output ev_outcome_e          outcome
);
    logic bit_hit;
    logic in_range;
    logic pf_exit;
    logic is_pf;

    gx_exc_select #(.NUM_EXC(NUM_EXC)) u_sel (
        .exc_bitmap (exc_bitmap),
        .vector     (req.vector),
        .bit_hit    (bit_hit),
        .in_range   (in_range)
    );

    gx_pf_filter #(.ERR_W(GX_ERR_W)) u_pf (
        .errcode (req.errcode),
        .mask    (pf_mask),
        .match   (pf_match),
        .pf_bit  (exc_bitmap[PF_VEC]),
        .pf_exit (pf_exit)
    );

    assign is_pf = (req.vector == GX_VEC_W'(PF_VEC));

    always_comb begin
        outcome = OUT_ERROR;
        case (req.kind)
            EV_EXTINT: outcome = extint_exit_en ? OUT_EXIT : OUT_RECORD;
            EV_NMI:    outcome = nmi_exit_en    ? OUT_EXIT : OUT_RECORD;
            EV_SWINT:  outcome = OUT_RECORD;
            EV_HWEXC, EV_PRIVSW, EV_SWEXC: begin
                if (!in_range)
                    outcome = OUT_ERROR;
                else if (is_pf)
                    outcome = pf_exit ? OUT_EXIT : OUT_RECORD;
                else
                    outcome = bit_hit ? OUT_EXIT : OUT_RECORD;
            end
            default:   outcome = OUT_ERROR;
        endcase
    end
endmodule

// File: rtl/gx_event_flags.sv
module gx_event_flags (
    input  logic clk,
    input  logic rst,
    input  logic nmi_set,
    input  logic nmi_clr,
    input  logic inev_set,
    input  logic inev_clr,
    output logic nmi_q,
    output logic inev_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            nmi_q  <= 1'b0;
            inev_q <= 1'b0;
        end else begin
            if (nmi_clr)
                nmi_q <= 1'b0;
            else if (nmi_set)
                nmi_q <= 1'b1;
            if (inev_clr)
                inev_q <= 1'b0;
            else if (inev_set)
                inev_q <= 1'b1;
        end
    end
endmodule

// File: rtl/gx_event_filter.sv
module gx_event_filter
    import gx_event_pkg::*;
#(
    parameter int NUM_EXC = 32
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   evt_valid,
    input  logic [GX_KIND_W-1:0]   evt_kind,
    input  logic [GX_VEC_W-1:0]    evt_vector,
    input  logic [GX_ERR_W-1:0]    evt_errcode,
    input  logic                   evt_err_valid,
    input  logic                   ctl_extint_exit,
    input  logic                   ctl_nmi_exit,
    input  logic [NUM_EXC-1:0]     exc_bitmap,
    input  logic [GX_ERR_W-1:0]    pf_err_mask,
    input  logic [GX_ERR_W-1:0]    pf_err_match,
    input  logic                   iret_unblock_set,
    input  logic                   delivery_start,
    input  logic [GX_QUAL_W-1:0]   dbg_trap,
    output logic                   exit_stb,
    output logic [GX_INFO_W-1:0]   exit_info,
    output logic [GX_ERR_W-1:0]    exit_errcode,
    output logic [GX_QUAL_W-1:0]   exit_qual,
    output logic                   rec_upd,
    output logic [GX_INFO_W-1:0]   rec_info,
    output logic [GX_ERR_W-1:0]    rec_errcode,
    output logic                   evt_bad,
    output logic                   nmi_unblock,
    output logic                   in_delivery
);
    ev_req_t     req;
    ev_outcome_e outcome;
    ev_outcome_e take;
    logic        nmi_q;
    logic        inev_q;

    always_comb begin
        req.kind      = ev_kind_e'(evt_kind);
        req.vector    = evt_vector;
        req.errcode   = evt_errcode;
        req.err_valid = evt_err_valid;
    end

    gx_exit_decide #(.NUM_EXC(NUM_EXC), .PF_VEC(int'(VEC_PFAULT))) u_decide (
        .req            (req),
        .extint_exit_en (ctl_extint_exit),
        .nmi_exit_en    (ctl_nmi_exit),
        .exc_bitmap     (exc_bitmap),
        .pf_mask        (pf_err_mask),
        .pf_match       (pf_err_match),
        .outcome        (outcome)
    );

    assign take = evt_valid ? outcome : OUT_NONE;

    gx_event_flags u_flags (
        .clk      (clk),
        .rst      (rst),
        .nmi_set  (iret_unblock_set),
        .nmi_clr  (take == OUT_RECORD),
        .inev_set (delivery_start),
        .inev_clr ((take == OUT_EXIT) && (evt_vector == VEC_DFAULT)),
        .nmi_q    (nmi_q),
        .inev_q   (inev_q)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            exit_stb     <= 1'b0;
            exit_info    <= '0;
            exit_errcode <= '0;
            exit_qual    <= '0;
            rec_upd      <= 1'b0;
            rec_info     <= '0;
            rec_errcode  <= '0;
            evt_bad      <= 1'b0;
        end else begin
            exit_stb <= (take == OUT_EXIT);
            rec_upd  <= (take == OUT_RECORD);
            evt_bad  <= (take == OUT_ERROR);
            if (take == OUT_EXIT) begin
                exit_info    <= pack_info(req, nmi_q, 1'b1);
                exit_errcode <= evt_errcode;
                exit_qual    <= (evt_vector == VEC_DEBUG) ? (dbg_trap & DBG_QUAL_KEEP) : '0;
            end
            if (take == OUT_RECORD) begin
                rec_info    <= pack_info(req, 1'b0, 1'b0);
                rec_errcode <= evt_errcode;
            end
        end
    end

    assign nmi_unblock = nmi_q;
    assign in_delivery = inev_q;
endmodule

// File: rtl/gx_event_filter_chk.sv
module gx_event_filter_chk (
    input logic        clk,
    input logic        rst,
    input logic        evt_valid,
    input logic [2:0]  evt_kind,
    input logic [7:0]  evt_vector,
    input logic        evt_err_valid,
    input logic        ctl_extint_exit,
    input logic        ctl_nmi_exit,
    input logic        exit_stb,
    input logic [31:0] exit_info,
    input logic [15:0] exit_qual,
    input logic        rec_upd,
    input logic [31:0] rec_info,
    input logic        evt_bad,
    input logic        nmi_unblock,
    input logic        in_delivery
);
    // R12
    one_strobe_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({exit_stb, rec_upd, evt_bad}));

    // R12
    strobe_cause_chk: assert property (@(posedge clk) disable iff (rst)
        (exit_stb || rec_upd || evt_bad) |-> $past(evt_valid));

    // R6
    exit_word_chk: assert property (@(posedge clk) disable iff (rst)
        exit_stb |-> (exit_info[31] && exit_info[30:13] == '0
                      && exit_info[7:0] == $past(evt_vector)
                      && exit_info[10:8] == $past(evt_kind)
                      && exit_info[11] == $past(evt_err_valid)
                      && exit_info[12] == $past(nmi_unblock)));

    // R7
    rec_word_chk: assert property (@(posedge clk) disable iff (rst)
        rec_upd |-> (rec_info[31:12] == '0 && !nmi_unblock
                     && rec_info[7:0] == $past(evt_vector)
                     && rec_info[10:8] == $past(evt_kind)
                     && rec_info[11] == $past(evt_err_valid)));

    // R1
    extint_gate_chk: assert property (@(posedge clk) disable iff (rst)
        (exit_stb && exit_info[10:8] == 3'd0) |-> $past(ctl_extint_exit));

    // R2
    nmi_gate_chk: assert property (@(posedge clk) disable iff (rst)
        (exit_stb && exit_info[10:8] == 3'd2) |-> $past(ctl_nmi_exit));

    // R5
    swint_no_exit_chk: assert property (@(posedge clk) disable iff (rst)
        exit_stb |-> (exit_info[10:8] != 3'd4));

    // R8
    qual_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (exit_stb && exit_info[7:0] != 8'd1) |-> (exit_qual == '0));

    // R9
    dfault_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (exit_stb && exit_info[7:0] == 8'd8) |-> !in_delivery);

    // R10
    bad_cause_chk: assert property (@(posedge clk) disable iff (rst)
        evt_bad |-> ($past(evt_kind) == 3'd1 || $past(evt_kind) == 3'd7
                     || $past(evt_vector) >= 8'd32));
endmodule

bind gx_event_filter gx_event_filter_chk u_chk (
    .clk             (clk),
    .rst             (rst),
    .evt_valid       (evt_valid),
    .evt_kind        (evt_kind),
    .evt_vector      (evt_vector),
    .evt_err_valid   (evt_err_valid),
    .ctl_extint_exit (ctl_extint_exit),
    .ctl_nmi_exit    (ctl_nmi_exit),
    .exit_stb        (exit_stb),
    .exit_info       (exit_info),
    .exit_qual       (exit_qual),
    .rec_upd         (rec_upd),
    .rec_info        (rec_info),
    .evt_bad         (evt_bad),
    .nmi_unblock     (nmi_unblock),
    .in_delivery     (in_delivery)
);

// File: tb/gx_event_filter_bench.sv
module gx_event_filter_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst;
    logic        evt_valid;
    logic [2:0]  evt_kind;
    logic [7:0]  evt_vector;
    logic [15:0] evt_errcode;
    logic        evt_err_valid;
    logic        ctl_extint_exit;
    logic        ctl_nmi_exit;
    logic [31:0] exc_bitmap;
    logic [15:0] pf_err_mask;
    logic [15:0] pf_err_match;
    logic        iret_unblock_set;
    logic        delivery_start;
    logic [15:0] dbg_trap;
    logic        exit_stb;
    logic [31:0] exit_info;
    logic [15:0] exit_errcode;
    logic [15:0] exit_qual;
    logic        rec_upd;
    logic [31:0] rec_info;
    logic [15:0] rec_errcode;
    logic        evt_bad;
    logic        nmi_unblock;
    logic        in_delivery;

    int n_chk  = 0;
    int n_fail = 0;
    logic done = 1'b0;
    logic exp_nmi  = 1'b0;
    logic exp_inev = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    gx_event_filter u_gx_event_filter (.*);

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // 1 exit, 2 record, 3 error
    function automatic int model(input int k, input int v, input logic [15:0] e);
        logic cm;
        if (k == 0) return ctl_extint_exit ? 1 : 2;
        if (k == 2) return ctl_nmi_exit ? 1 : 2;
        if (k == 4) return 2;
        if (k == 3 || k == 5 || k == 6) begin
            if (v >= 32) return 3;
            if (v == 14) begin
                cm = ((e & pf_err_mask) == pf_err_match);
                return (cm == exc_bitmap[14]) ? 1 : 2;
            end
            return exc_bitmap[v] ? 1 : 2;
        end
        return 3;
    endfunction

    function automatic string tag_of(input int k, input int v);
        if (k == 0) return "R1";
        if (k == 2) return "R2";
        if (k == 4) return "R5";
        if (k == 1 || k == 7 || v >= 32) return "R10";
        if (v == 14) return "R4";
        return "R3";
    endfunction

    task automatic pulse_nmi();
        @(negedge clk); iret_unblock_set = 1'b1;
        @(negedge clk); iret_unblock_set = 1'b0;
        exp_nmi = 1'b1;
        chk("R13 nmi set", {31'd0, nmi_unblock}, 32'd1);
    endtask

    task automatic pulse_inev();
        @(negedge clk); delivery_start = 1'b1;
        @(negedge clk); delivery_start = 1'b0;
        exp_inev = 1'b1;
        chk("R13 delivery set", {31'd0, in_delivery}, 32'd1);
    endtask

    task automatic run_event(input int k, input int v, input logic ev);
        int          res;
        string       tg;
        logic [15:0] e;
        logic [15:0] d;
        logic [31:0] old_exit;
        logic [31:0] old_rec;
        logic [31:0] word;
        e  = {8'(v), 5'd0, ev ? 3'd5 : 3'd2};
        d  = 16'hFFFF ^ {8'(v), 8'(v)};
        tg = tag_of(k, v);
        old_exit = exit_info;
        old_rec  = rec_info;
        @(negedge clk);
        evt_valid = 1'b1; evt_kind = 3'(k); evt_vector = 8'(v);
        evt_errcode = e; evt_err_valid = ev; dbg_trap = d;
        res = model(k, v, e);
        word = {19'd0, ev, 3'(k), 8'(v)};
        @(negedge clk);
        evt_valid = 1'b0;
        chk({tg, " strobes"}, {29'd0, exit_stb, rec_upd, evt_bad},
            {29'd0, res == 1, res == 2, res == 3});
        if (res == 1) begin
            word[31] = 1'b1; word[12] = exp_nmi;
            chk({tg, " R6 exit_info"}, exit_info, word);
            chk({tg, " R6 exit_errcode"}, {16'd0, exit_errcode}, {16'd0, e});
            chk({tg, " R8 exit_qual"}, {16'd0, exit_qual},
                {16'd0, (v == 1) ? (d & 16'h600F) : 16'h0});
            if (v == 8) exp_inev = 1'b0;
        end else if (res == 2) begin
            chk({tg, " R7 rec_info"}, rec_info, word);
            chk({tg, " R7 rec_errcode"}, {16'd0, rec_errcode}, {16'd0, e});
            exp_nmi = 1'b0;
        end else begin
            chk({tg, " R10 exit_info kept"}, exit_info, old_exit);
            chk({tg, " R10 rec_info kept"}, rec_info, old_rec);
        end
        chk({tg, " R7 nmi flag"}, {31'd0, nmi_unblock}, {31'd0, exp_nmi});
        chk({tg, " R9 delivery flag"}, {31'd0, in_delivery}, {31'd0, exp_inev});
        @(negedge clk);
        chk({tg, " R12 strobes drop"}, {29'd0, exit_stb, rec_upd, evt_bad}, 32'd0);
    endtask

    initial begin
        rst = 1'b1; evt_valid = 1'b0; evt_kind = '0; evt_vector = '0;
        evt_errcode = '0; evt_err_valid = 1'b0; ctl_extint_exit = 1'b0;
        ctl_nmi_exit = 1'b0; exc_bitmap = '0; pf_err_mask = '0;
        pf_err_match = '0; iret_unblock_set = 1'b0; delivery_start = 1'b0;
        dbg_trap = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R11 reset state
        chk("R11 strobes", {29'd0, exit_stb, rec_upd, evt_bad}, 32'd0);
        chk("R11 exit_info", exit_info, 32'd0);
        chk("R11 rec_info", rec_info, 32'd0);
        chk("R11 codes", {exit_errcode, rec_errcode}, 32'd0);
        chk("R11 qual/flags", {14'd0, exit_qual, nmi_unblock, in_delivery}, 32'd0);

        for (int cfg = 0; cfg < 4; cfg++) begin
            ctl_extint_exit = cfg[0];
            ctl_nmi_exit    = cfg[1];
            case (cfg)
                0: exc_bitmap = 32'h5A5A_4F15;
                1: exc_bitmap = 32'hA5A5_B0EA;
                2: exc_bitmap = 32'hFFFF_FFFF;
                default: exc_bitmap = 32'h0000_0000;
            endcase
            pf_err_mask  = cfg[0] ? 16'h0000 : 16'h0007;
            pf_err_match = cfg[0] ? 16'h0000 : 16'h0005;
            for (int k = 0; k < 8; k++) begin
                for (int v = 0; v < 40; v++) begin
                    for (int ev = 0; ev < 2; ev++) begin
                        if ((v % 3) == 0 && ev == 0) pulse_nmi();
                        if ((v % 4) == 0 && ev == 1) pulse_inev();
                        run_event(k, v, ev[0]);
                    end
                end
            end
        end

        // R13 collision: set pulse with a recorded event, clear wins
        pulse_nmi();
        @(negedge clk);
        evt_valid = 1'b1; evt_kind = 3'd4; evt_vector = 8'd3;
        evt_errcode = 16'h0; evt_err_valid = 1'b0; iret_unblock_set = 1'b1;
        @(negedge clk);
        evt_valid = 1'b0; iret_unblock_set = 1'b0;
        chk("R13 clear beats set", {31'd0, nmi_unblock}, 32'd0);

        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule